// File: doc/BRIEF.md
# Start/Stop Stopwatch Time Counter

This block keeps elapsed time as six BCD digits in 24-hour hours, minutes and seconds. It runs from one fast system clock. A divider inside the block makes a one-second enable, and all digit counters take that enable; none is clocked by a derived clock. Two active-low push buttons control it. The run button alternates between counting and holding the elapsed time. The clear button returns every digit to zero and leaves the block paused.

Each button passes through a two-flop synchroniser and a debounce filter, and each accepted press becomes a single-cycle event. The digits form a mixed-radix carry chain. Seconds and minutes roll over at 59, and hours roll over from 23 to 00. Every digit is also decoded to an active-low seven-segment pattern. A BCD code above 9 decodes to a blank (all segments high), although the chain never produces one.

Top module: `stopwatch_core`

## Requirements
- R1: The buttons are active low and are synchronised and debounced. One press produces exactly one event, however long the button is held. Contact bounce made of low pulses shorter than DEB_CYC cycles produces no event.
- R2: Each run-button event switches between running and paused. The first event after reset starts counting. A later event resumes from the held time.
- R3: A clear-button event sets all digits to zero, clears the one-second divider and leaves the block paused. If a clear event arrives in the same cycle as a run event or a one-second tick, the clear takes precedence.
- R4: While the block is running, the time advances by exactly one second every 2*HALF_COUNT clock cycles.
- R5: While the block is paused, every digit holds its value.
- R6: `time_bcd` is packed as {hours tens, hours units, minutes tens, minutes units, seconds tens, seconds units}, 4 bits each, with seconds units in bits 3:0. The seconds and minutes units digits count 0 to 9, and the tens digits count 0 to 5. A digit that wraps to 0 advances the next digit.
- R7: The hours tens digit counts 0 to 2. The hours units digit counts 0 to 9, except 0 to 3 when the tens digit is 2. After 23:59:59 the next second gives 00:00:00.
- R8: `seg_n` holds 7 bits per digit, in the same digit order as `time_bcd`. Within each group, bit 6 is segment a and bit 0 is segment g, and a 0 lights the segment. The patterns are 0=0000001, 1=1001111, 2=0010010, 3=0000110, 4=1001100, 5=0100100, 6=0100000, 7=0001111, 8=0000000, 9=0000100.
- R9: The asynchronous active-low reset `rst_n` zeroes the time and the divider and leaves the block paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_run_n | input | 1 | Run/pause push button, active low, asynchronous |
| btn_clr_n | input | 1 | Clear push button, active low, asynchronous |
| time_bcd | output | 24 | Six BCD digits, packed as in R6 |
| seg_n | output | 42 | Six active-low segment patterns, packed as in R8 |

## Verification
The run button is driven with clean presses, very long holds, bounce bursts followed by a hold, and short glitches alone. Only the first three should change the run state. Comparing a 20-cycle window against a ten-second advance tells a running block from a paused one, and it also exposes a wrong tick rate. Pressing both buttons together while paused separates a correct clear priority from a block that starts running. A full day of counting, checked at every change against the next second computed in the bench, covers every carry, the 19-to-20 and 23-to-00 hour cases, and every segment pattern.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int NDIG = 6;
  typedef logic [3:0] bcd_t;

  // Highest value a digit may hold; the hours units limit follows the hours tens digit.
  function automatic bcd_t digit_limit(input int idx, input bcd_t hr_tens);
    case (idx)
      0, 2:    digit_limit = 4'd9;
      1, 3:    digit_limit = 4'd5;
      4:       digit_limit = (hr_tens == 4'd2) ? 4'd3 : 4'd9;
      default: digit_limit = 4'd2;
    endcase
  endfunction

  function automatic bcd_t bcd_step(input bcd_t d, input bcd_t lim);
    bcd_step = (d == lim) ? 4'd0 : d + 4'd1;
  endfunction

  // Active-low pattern, bit 6 = segment a ... bit 0 = segment g.
  function automatic logic [6:0] bcd_to_seg_n(input bcd_t d);
    case (d)
      4'd0: bcd_to_seg_n = 7'b0000001;
      4'd1: bcd_to_seg_n = 7'b1001111;
      4'd2: bcd_to_seg_n = 7'b0010010;
      4'd3: bcd_to_seg_n = 7'b0000110;
      4'd4: bcd_to_seg_n = 7'b1001100;
      4'd5: bcd_to_seg_n = 7'b0100100;
      4'd6: bcd_to_seg_n = 7'b0100000;
      4'd7: bcd_to_seg_n = 7'b0001111;
      4'd8: bcd_to_seg_n = 7'b0000000;
      4'd9: bcd_to_seg_n = 7'b0000100;
      default: bcd_to_seg_n = 7'b1111111;
    endcase
  endfunction
endpackage

// File: rtl/sw_btn_cond.sv
module sw_btn_cond #(
  parameter int DEB_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic press
);
  localparam int CW = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;

  logic          sync1, sync2, stable;
  logic [CW-1:0] cnt;
  logic          accept;

  assign accept = (sync2 != stable) && (cnt == CW'(DEB_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= 1'b0;
      sync2  <= 1'b0;
      stable <= 1'b0;
      cnt    <= '0;
      press  <= 1'b0;
    end else begin
      sync1 <= ~pin_n;
      sync2 <= sync1;
      press <= accept && sync2;
      if (sync2 == stable) begin
        cnt <= '0;
      end else if (accept) begin
        stable <= sync2;
        cnt    <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> !press);
endmodule

// File: rtl/sw_tick_gen.sv
module sw_tick_gen #(
  parameter int HALF_COUNT = 25000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_COUNT > 1) ? $clog2(HALF_COUNT) : 1;

  logic [CW-1:0] cnt;
  logic          phase;
  logic          half_done;

  assign half_done = (cnt == CW'(HALF_COUNT - 1));
  assign tick      = en && !clr && half_done && phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (clr) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (en) begin
      if (half_done) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/sw_time_chain.sv
module sw_time_chain
  import sw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic [4*NDIG-1:0] time_bcd
);
  bcd_t dig   [NDIG];
  bcd_t lim   [NDIG];
  logic [NDIG:0] carry;

  assign carry[0] = adv && !clr;

  for (genvar i = 0; i < NDIG; i++) begin : g_digit
    assign lim[i]            = digit_limit(i, dig[NDIG-1]);
    assign carry[i+1]        = carry[i] && (dig[i] == lim[i]);
    assign time_bcd[4*i +: 4] = dig[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dig[i] <= 4'd0;
      else if (clr)      dig[i] <= 4'd0;
      else if (carry[i]) dig[i] <= bcd_step(dig[i], lim[i]);
    end

    if (i < 4) begin : g_ms
      assert_digit_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dig[i] <= ((i % 2 == 0) ? 4'd9 : 4'd5));
    end else begin : g_hr
      assert_hour_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dig[5] <= 4'd2) && (dig[5] != 4'd2 || dig[4] <= 4'd3));
    end
  end

  assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(time_bcd));
  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (time_bcd == '0));
  assert_day_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (time_bcd == 24'h235959 && adv && !clr) |=> (time_bcd == '0));
endmodule

// File: rtl/sw_seg_decode.sv
module sw_seg_decode
  import sw_pkg::*;
(
  input  logic [4*NDIG-1:0] time_bcd,
  output logic [7*NDIG-1:0] seg_n
);
  for (genvar i = 0; i < NDIG; i++) begin : g_dec
    assign seg_n[7*i +: 7] = bcd_to_seg_n(time_bcd[4*i +: 4]);
  end
endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core
  import sw_pkg::*;
#(
  parameter int HALF_COUNT = 25000000,
  parameter int DEB_CYC    = 50000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        btn_run_n,
  input  logic        btn_clr_n,
  output logic [23:0] time_bcd,
  output logic [41:0] seg_n
);
  logic run_evt, clr_evt, running, sec_tick;

  sw_btn_cond #(.DEB_CYC(DEB_CYC)) u_run_btn (
    .clk(clk), .rst_n(rst_n), .pin_n(btn_run_n), .press(run_evt));
  sw_btn_cond #(.DEB_CYC(DEB_CYC)) u_clr_btn (
    .clk(clk), .rst_n(rst_n), .pin_n(btn_clr_n), .press(clr_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       running <= 1'b0;
    else if (clr_evt) running <= 1'b0;
    else if (run_evt) running <= ~running;
  end

  sw_tick_gen #(.HALF_COUNT(HALF_COUNT)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(clr_evt), .en(running), .tick(sec_tick));

  sw_time_chain u_chain (
    .clk(clk), .rst_n(rst_n), .clr(clr_evt), .adv(sec_tick), .time_bcd(time_bcd));

  sw_seg_decode u_dec (.time_bcd(time_bcd), .seg_n(seg_n));

  assert_run_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_evt && !clr_evt) |=> (running != $past(running)));
  assert_clear_pauses_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !running);
  assert_paused_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !sec_tick);
endmodule

// File: tb/tb_stopwatch_core.sv
module tb_stopwatch_core;
  localparam int HALF = 1;
  localparam int DEB  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        btn_run_n = 1'b1;
  logic        btn_clr_n = 1'b1;
  logic [23:0] time_bcd;
  logic [41:0] seg_n;

  int  n_chk = 0;
  int  n_fail = 0;
  int  cycles = 0;
  bit  exp_run = 1'b0;
  bit  mon_on = 1'b0;
  bit  done = 1'b0;
  logic [23:0] prev;

  stopwatch_core #(.HALF_COUNT(HALF), .DEB_CYC(DEB)) dut (
    .clk(clk), .rst_n(rst_n), .btn_run_n(btn_run_n), .btn_clr_n(btn_clr_n),
    .time_bcd(time_bcd), .seg_n(seg_n));

  always #2.5 clk = ~clk;

  function automatic int to_sec(input logic [23:0] t);
    return (t[23:20]*10 + t[19:16]) * 3600 + (t[15:12]*10 + t[11:8]) * 60
         + t[7:4]*10 + t[3:0];
  endfunction

  function automatic logic [23:0] from_sec(input int s);
    int h, m, c;
    h = s / 3600; m = (s / 60) % 60; c = s % 60;
    return {4'(h/10), 4'(h%10), 4'(m/10), 4'(m%10), 4'(c/10), 4'(c%10)};
  endfunction

  function automatic logic [23:0] add_secs(input logic [23:0] t, input int n);
    return from_sec((to_sec(t) + n) % 86400);
  endfunction

  // Lit segments written active high, then inverted.
  function automatic logic [6:0] lit(input logic [3:0] d);
    logic [6:0] on;
    case (d)
      4'd0: on = 7'b1111110; 4'd1: on = 7'b0110000; 4'd2: on = 7'b1101101;
      4'd3: on = 7'b1111001; 4'd4: on = 7'b0110011; 4'd5: on = 7'b1011011;
      4'd6: on = 7'b1011111; 4'd7: on = 7'b1110000; 4'd8: on = 7'b1111111;
      default: on = 7'b1111011;
    endcase
    return ~on;
  endfunction

  function automatic logic [41:0] exp_seg(input logic [23:0] t);
    logic [41:0] r;
    for (int i = 0; i < 6; i++) r[7*i +: 7] = lit(t[4*i +: 4]);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [47:0] act,
                     input logic [47:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, expv, cycles);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic press(input bit clr, input int hold);
    if (clr) btn_clr_n = 1'b0; else btn_run_n = 1'b0;
    wait_cyc(hold);
    btn_clr_n = 1'b1; btn_run_n = 1'b1;
    wait_cyc(16);
    if (clr) exp_run = 1'b0; else exp_run = ~exp_run;
  endtask

  task automatic bounce(input int bursts);
    for (int k = 0; k < bursts; k++) begin
      btn_run_n = 1'b0; wait_cyc(1 + $urandom % 2);
      btn_run_n = 1'b1; wait_cyc(1 + $urandom % 2);
    end
  endtask

  task automatic check_state(input string req);
    logic [23:0] t0;
    t0 = time_bcd;
    wait_cyc(20);
    if (exp_run) chk(time_bcd == add_secs(t0, 10), req, {24'd0, time_bcd}, {24'd0, add_secs(t0, 10)});
    else         chk(time_bcd == t0, req, {24'd0, time_bcd}, {24'd0, t0});
  endtask

  // Every change must be the next second or a clear; segments always match the digits.
  always @(negedge clk) begin
    cycles++;
    if (mon_on) begin
      if (time_bcd != prev)
        chk(time_bcd == add_secs(prev, 1) || time_bcd == 24'h0, "R6 R7 step",
            {24'd0, time_bcd}, {24'd0, add_secs(prev, 1)});
      chk(seg_n == exp_seg(time_bcd), "R8 segments", {6'd0, seg_n}, {6'd0, exp_seg(time_bcd)});
    end
    prev = time_bcd;
  end

  initial begin
    wait_cyc(195000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] t;
    void'($urandom(32'd2024));
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(1);
    mon_on = 1'b1;
    chk(time_bcd == 24'h0, "R9 reset time", {24'd0, time_bcd}, 48'd0);
    chk(seg_n == {6{7'b0000001}}, "R8 zero pattern", {6'd0, seg_n}, {6'd0, {6{7'b0000001}}});
    check_state("R9 paused after reset");

    press(1'b0, 10); check_state("R2 first press starts / R4 rate");
    press(1'b0, 10); check_state("R5 pause holds");
    press(1'b0, 10); check_state("R2 resume from held value");
    press(1'b0, 100); check_state("R1 long hold one event");
    bounce(3); press(1'b0, 12); check_state("R1 bounce then hold one event");
    press(1'b1, 10);
    chk(time_bcd == 24'h0, "R3 clear zeroes", {24'd0, time_bcd}, 48'd0);
    check_state("R3 clear leaves paused");

    for (int it = 0; it < 60; it++) begin
      case ($urandom % 4)
        0: press(1'b0, 8 + $urandom % 25);
        1: begin press(1'b1, 8 + $urandom % 10);
             chk(time_bcd == 24'h0, "R3 random clear", {24'd0, time_bcd}, 48'd0); end
        2: begin bounce(1 + $urandom % 4); wait_cyc(16); end
        default: wait_cyc(1 + $urandom % 50);
      endcase
      check_state("R4 R5 random window");
    end

    // Both buttons together while paused: clear must win over run.
    if (exp_run) press(1'b0, 10);
    btn_run_n = 1'b0; btn_clr_n = 1'b0;
    wait_cyc(12);
    btn_run_n = 1'b1; btn_clr_n = 1'b1;
    wait_cyc(16);
    exp_run = 1'b0;
    chk(time_bcd == 24'h0, "R3 clear beats run", {24'd0, time_bcd}, 48'd0);
    check_state("R3 clear beats run stays paused");

    // Full day from zero through the 23:59:59 wrap.
    press(1'b1, 10);
    press(1'b0, 10);
    while (time_bcd != 24'h235959 && cycles < 190000) @(negedge clk);
    chk(time_bcd == 24'h235959, "R7 reached 23:59:59", {24'd0, time_bcd}, {24'd0, 24'h235959});
    t = time_bcd;
    while (time_bcd == t && cycles < 190000) @(negedge clk);
    chk(time_bcd == 24'h0, "R7 wrap to 00:00:00", {24'd0, time_bcd}, 48'd0);
    check_state("R4 running after wrap");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule